// File: doc/BRIEF.md
# Frame-Synchronized Serial Transmitter

This block sends a parallel word out one bit at a time on a single data line, timed by a serial bit clock and started by a frame-sync pulse. The host writes an 8- or 16-bit word into a one-entry transmit buffer. When a frame-sync pulse is seen, the word moves into a shift register, the buffer reports empty and an interrupt pulse fires. The bits then leave most significant first, one per rising serial-clock edge. The data driver is enabled only while a frame is on the line.

The serial clock and the frame-sync each come either from an input pin or from an on-block generator, and the two choices are independent. External inputs are brought into the single system clock domain through synchronizers, and serial-clock edges are found by comparing successive samples. If the frame-sync stays high for longer than one bit period, the first bit stays on the line until frame-sync drops. If a frame starts while the buffer is still empty, the previous word is sent again and an underflow flag is raised.

Top module: `ftx_serial_tx`

## Requirements
- R1: `cfg_wlen16`=1 selects 16-bit words taken from `wr_data[15:0]`. `cfg_wlen16`=0 selects 8-bit words taken from `wr_data[7:0]`, and the upper byte is ignored. The length is latched when a frame is accepted.
- R2: Bits leave on `txd` most significant first. Every bit of the word is sent exactly once unless R5 applies.
- R3: `txd` and `txd_oe` change only in the system cycle that follows a detected rising serial-clock edge. The first bit is driven at the rising edge that follows the accepting falling edge.
- R4: A frame is accepted at a falling serial-clock edge where frame-sync is high and was low at the previous falling edge. A frame is accepted only while the line is idle or the last bit of the current word is on the line; a frame-sync pulse at any other time has no effect.
- R5: If frame-sync is still high at the rising edge after the first bit was driven, the first bit is held. Shifting resumes at the first rising edge at which frame-sync is low.
- R6: At the rising edge after the last bit, `txd_oe` drops to 0, unless a new frame was accepted during the last bit. In that case the new word's first bit follows with no gap.
- R7: Accepting a frame raises `tx_irq` for exactly one system cycle and sets `buf_empty`. A write (`wr_en`=1) clears `buf_empty`.
- R8: A frame accepted while `buf_empty`=1 resends the last written word and sets `underflow`. The next write clears `underflow`.
- R9: `cfg_int_clk`=1 uses the internal serial clock, with a period of CLK_DIV system cycles. `cfg_int_fs`=1 uses the internal frame-sync, which changes on rising serial-clock edges and is high for one bit period every FRAME_LEN bits. Each choice works with either setting of the other.
- R10: After reset: `txd_oe`=0, `txd`=0, `tx_irq`=0, `buf_empty`=1, `underflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wlen16 | input | 1 | 1: 16-bit words, 0: 8-bit words |
| cfg_int_clk | input | 1 | 1: internal serial clock, 0: ext_sclk |
| cfg_int_fs | input | 1 | 1: internal frame-sync, 0: ext_fsync |
| ext_sclk | input | 1 | External serial clock (asynchronous) |
| ext_fsync | input | 1 | External frame-sync (asynchronous) |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | WORD_W | Word to transmit |
| sclk_out | output | 1 | Internally generated serial clock |
| fsync_out | output | 1 | Internally generated frame-sync |
| txd | output | 1 | Serial data |
| txd_oe | output | 1 | Driver enable for txd (0 = high impedance) |
| tx_irq | output | 1 | One-cycle buffer-empty interrupt |
| buf_empty | output | 1 | Transmit buffer holds no new word |
| underflow | output | 1 | A frame started with an empty buffer |

## Verification
The assertions assume that an external serial clock has a period of at least six system cycles, so rising and falling edge pulses are at least three cycles apart. They also assume that frame-sync changes only near rising serial-clock edges, so it is settled when the falling edge samples it. The assertions further assume that the source selects change only while reset is asserted, so switching sources never creates a false edge. The bench drives `ext_sclk` with a 12-cycle period and changes `ext_fsync` in the same cycle as the rising edge. It applies reset before every change of clock or frame-sync source.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_FIRST = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ftx_sync.sv
// Multi-stage synchronizer, one chain per input bit.
module ftx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in[i]};
      end
      assign level[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ftx_clk_gen.sv
// Internal serial clock divider and frame-sync generator.
module ftx_clk_gen #(
  parameter int CLK_DIV   = 12,
  parameter int FRAME_LEN = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_rise,
  output logic sclk_int,
  output logic fsync_int
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int FW   = $clog2(FRAME_LEN);
  localparam logic [DW-1:0] DIV_LAST   = DW'(HALF - 1);
  localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_LEN - 1);

  logic [DW-1:0] div_cnt;
  logic [FW-1:0] frm_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt  <= '0;
      sclk_int <= 1'b0;
    end else if (div_cnt == DIV_LAST) begin
      div_cnt  <= '0;
      sclk_int <= ~sclk_int;
    end else begin
      div_cnt  <= div_cnt + 1'b1;
    end
  end

  // Frame counter runs on the selected serial clock, so it also serves an external clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      frm_cnt   <= FRAME_LAST;
      fsync_int <= 1'b0;
    end else if (sel_rise) begin
      if (frm_cnt == FRAME_LAST) begin
        frm_cnt   <= '0;
        fsync_int <= 1'b1;
      end else begin
        frm_cnt   <= frm_cnt + 1'b1;
        fsync_int <= 1'b0;
      end
    end
  end

  AST_FS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !sel_rise |=> $stable(fsync_int)); // R9
endmodule

// File: rtl/ftx_shifter.sv
// Transmit buffer, shift register and frame sequencing.
module ftx_shifter
  import ftx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sc_rise,
  input  logic              sc_fall,
  input  logic              fs,
  input  logic              wlen16,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              txd,
  output logic              txd_oe,
  output logic              tx_irq,
  output logic              buf_empty,
  output logic              underflow
);
  localparam int SHORT_W = WORD_W / 2;
  localparam int CNT_W   = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LONG_CNT  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_W);

  tx_state_e         state;
  logic [WORD_W-1:0] buf_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              wl16_q;
  logic              start_pend;
  logic              fs_prev;
  logic              last_bit;
  logic              can_accept;
  logic              accept;

  assign last_bit   = (state == TX_SHIFT) && (bitcnt == (wl16_q ? LONG_CNT : SHORT_CNT));
  assign can_accept = ((state == TX_IDLE) || last_bit) && !start_pend;
  assign accept     = sc_fall && fs && !fs_prev && can_accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TX_IDLE;
      buf_q      <= '0;
      shreg      <= '0;
      bitcnt     <= '0;
      wl16_q     <= 1'b0;
      start_pend <= 1'b0;
      fs_prev    <= 1'b0;
      txd        <= 1'b0;
      txd_oe     <= 1'b0;
      tx_irq     <= 1'b0;
      buf_empty  <= 1'b1;
      underflow  <= 1'b0;
    end else begin
      tx_irq <= 1'b0;
      if (sc_fall) fs_prev <= fs;

      if (accept) begin
        shreg      <= wlen16 ? buf_q : {buf_q[SHORT_W-1:0], {SHORT_W{1'b0}}};
        wl16_q     <= wlen16;
        start_pend <= 1'b1;
        tx_irq     <= 1'b1;
        buf_empty  <= 1'b1;
        if (buf_empty) underflow <= 1'b1;
      end

      // A write in the accepting cycle lands after the old word was taken.
      if (wr_en) begin
        buf_q     <= wr_data;
        buf_empty <= 1'b0;
        underflow <= 1'b0;
      end

      if (sc_rise) begin
        if (start_pend) begin
          txd        <= shreg[WORD_W-1];
          shreg      <= {shreg[WORD_W-2:0], 1'b0};
          txd_oe     <= 1'b1;
          bitcnt     <= CNT_W'(1);
          state      <= TX_FIRST;
          start_pend <= 1'b0;
        end else begin
          case (state)
            TX_FIRST: begin
              if (!fs) begin
                txd    <= shreg[WORD_W-1];
                shreg  <= {shreg[WORD_W-2:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
                state  <= TX_SHIFT;
              end
            end
            TX_SHIFT: begin
              if (last_bit) begin
                txd    <= 1'b0;
                txd_oe <= 1'b0;
                state  <= TX_IDLE;
              end else begin
                txd    <= shreg[WORD_W-1];
                shreg  <= {shreg[WORD_W-2:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
              end
            end
            default: state <= TX_IDLE;
          endcase
        end
      end
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq); // R7
  AST_EMPTY_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> (buf_empty || $past(wr_en))); // R7
  AST_TXD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !sc_rise |=> ($stable(txd) && $stable(txd_oe))); // R3
  AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (rst)
    (state == TX_FIRST && sc_rise && fs && !start_pend) |=> (state == TX_FIRST && $stable(txd))); // R5
  AST_UNDERFLOW_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow) |-> tx_irq); // R8
  AST_OE_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $fell(txd_oe) |-> $past(sc_rise)); // R6
endmodule

// File: rtl/ftx_serial_tx.sv
// Top: source selection, serial-clock edge detection, transmit datapath.
module ftx_serial_tx #(
  parameter int WORD_W      = 16,
  parameter int CLK_DIV     = 12,
  parameter int FRAME_LEN   = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wlen16,
  input  logic              cfg_int_clk,
  input  logic              cfg_int_fs,
  input  logic              ext_sclk,
  input  logic              ext_fsync,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              sclk_out,
  output logic              fsync_out,
  output logic              txd,
  output logic              txd_oe,
  output logic              tx_irq,
  output logic              buf_empty,
  output logic              underflow
);
  logic [1:0] ext_lvl;
  logic       sclk_int;
  logic       fsync_int;
  logic       sel_sclk;
  logic       sclk_d;
  logic       sc_rise;
  logic       sc_fall;
  logic       fs_lvl;

  ftx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({ext_fsync, ext_sclk}),
    .level    (ext_lvl)
  );

  ftx_clk_gen #(.CLK_DIV(CLK_DIV), .FRAME_LEN(FRAME_LEN)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .sel_rise  (sc_rise),
    .sclk_int  (sclk_int),
    .fsync_int (fsync_int)
  );

  assign sel_sclk = cfg_int_clk ? sclk_int : ext_lvl[0];
  assign fs_lvl   = cfg_int_fs ? fsync_int : ext_lvl[1];

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sel_sclk;
  end

  assign sc_rise = sel_sclk & ~sclk_d;
  assign sc_fall = ~sel_sclk & sclk_d;

  ftx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sc_rise   (sc_rise),
    .sc_fall   (sc_fall),
    .fs        (fs_lvl),
    .wlen16    (cfg_wlen16),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .txd       (txd),
    .txd_oe    (txd_oe),
    .tx_irq    (tx_irq),
    .buf_empty (buf_empty),
    .underflow (underflow)
  );

  assign sclk_out  = sclk_int;
  assign fsync_out = fsync_int;
endmodule

// File: tb/tb_ftx_serial_tx.sv
module tb_ftx_serial_tx;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wlen16, cfg_int_clk, cfg_int_fs;
  logic        ext_sclk, ext_fsync, wr_en;
  logic [15:0] wr_data;
  logic        sclk_out, fsync_out, txd, txd_oe, tx_irq, buf_empty, underflow;

  int vectors = 0;
  int miscompares = 0;
  int irq_cnt = 0;
  logic s_oe, s_d;

  always #2 clk = ~clk;

  ftx_serial_tx dut (
    .clk(clk), .rst(rst), .cfg_wlen16(cfg_wlen16), .cfg_int_clk(cfg_int_clk),
    .cfg_int_fs(cfg_int_fs), .ext_sclk(ext_sclk), .ext_fsync(ext_fsync),
    .wr_en(wr_en), .wr_data(wr_data), .sclk_out(sclk_out), .fsync_out(fsync_out),
    .txd(txd), .txd_oe(txd_oe), .tx_irq(tx_irq), .buf_empty(buf_empty),
    .underflow(underflow)
  );

  always @(posedge clk) if (!rst && tx_irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic bit_of(input logic [15:0] w, input bit wl16, input int i);
    return wl16 ? w[15-i] : w[7-i];
  endfunction

  task automatic do_reset(input logic iclk, input logic ifs);
    @(negedge clk);
    rst = 1'b1; cfg_int_clk = iclk; cfg_int_fs = ifs;
    ext_sclk = 1'b0; ext_fsync = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_word(input logic [15:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // One external serial period of 12 system cycles; samples late in the high phase.
  task automatic cyc(input logic fs);
    @(negedge clk); ext_sclk = 1'b1; ext_fsync = fs;
    repeat (6) @(negedge clk);
    s_oe = txd_oe; s_d = txd;
    ext_sclk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    chk("R10 oe", {15'd0, txd_oe}, 16'd0);
    chk("R10 txd", {15'd0, txd}, 16'd0);
    chk("R10 irq", {15'd0, tx_irq}, 16'd0);
    chk("R10 empty", {15'd0, buf_empty}, 16'd1);
    chk("R10 underflow", {15'd0, underflow}, 16'd0);
  endtask

  task automatic t_frame(input logic [15:0] w, input bit wl16, input int fs_len,
                         input int glitch, input bit do_wr, input string req);
    int wl = wl16 ? 16 : 8;
    int hold = (fs_len > 1) ? fs_len - 1 : 1;
    int irq0;
    cfg_wlen16 = wl16;
    if (do_wr) begin
      write_word(w);
      chk("R7 empty cleared by write", {15'd0, buf_empty}, 16'd0);
    end
    irq0 = irq_cnt;
    cyc(1'b1);
    for (int n = 0; n < hold; n++) begin
      cyc((n + 1) < fs_len);
      chk({req, " first bit oe"}, {15'd0, s_oe}, 16'd1);
      chk({req, " first bit"}, {15'd0, s_d}, {15'd0, bit_of(w, wl16, 0)});
    end
    for (int b = 1; b < wl; b++) begin
      cyc(b == glitch);
      chk({req, " bit"}, {15'd0, s_d}, {15'd0, bit_of(w, wl16, b)});
    end
    cyc(1'b0);
    chk("R6 oe released", {15'd0, s_oe}, 16'd0);
    chk("R7 one irq per frame", 16'(irq_cnt - irq0), 16'd1);
    chk("R7 empty after frame", {15'd0, buf_empty}, 16'd1);
  endtask

  task automatic t_chain(input logic [15:0] a, input logic [15:0] b);
    int irq0;
    cfg_wlen16 = 1'b0;
    write_word(a);
    irq0 = irq_cnt;
    cyc(1'b1);
    cyc(1'b0);
    chk("R6 chain A msb", {15'd0, s_d}, {15'd0, a[7]});
    write_word(b);
    for (int i = 1; i < 8; i++) begin
      cyc(i == 7);
      chk("R6 chain A bit", {15'd0, s_d}, {15'd0, a[7-i]});
    end
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0);
      chk("R6 chain B oe", {15'd0, s_oe}, 16'd1);
      chk("R6 chain B bit", {15'd0, s_d}, {15'd0, b[7-i]});
    end
    cyc(1'b0);
    chk("R6 chain end oe", {15'd0, s_oe}, 16'd0);
    chk("R6 chain irq count", 16'(irq_cnt - irq0), 16'd2);
  endtask

  task automatic t_underflow(input logic [15:0] last);
    t_frame(last, 1'b0, 1, 0, 1'b0, "R8 resend");
    chk("R8 underflow set", {15'd0, underflow}, 16'd1);
    write_word(16'h0033);
    chk("R8 underflow cleared", {15'd0, underflow}, 16'd0);
  endtask

  task automatic t_internal(input logic [15:0] w);
    realtime t0, t1;
    int irq0;
    do_reset(1'b1, 1'b1);
    cfg_wlen16 = 1'b1;
    irq0 = irq_cnt;
    write_word(w);
    @(posedge fsync_out);
    for (int i = 0; i < 16; i++) begin
      @(posedge sclk_out);
      if (i == 0) t0 = $realtime;
      if (i == 1) begin
        t1 = $realtime;
        chk("R9 internal clock period", 16'((t1 - t0) / 4.0), 16'd12);
      end
      @(posedge clk); @(negedge clk);
      chk("R9 int clk+fs bit", {15'd0, txd}, {15'd0, w[15-i]});
    end
    chk("R9 int frame irq", 16'(irq_cnt - irq0), 16'd1);
  endtask

  task automatic t_mixed(input logic [15:0] w);
    do_reset(1'b1, 1'b0);
    cfg_wlen16 = 1'b0;
    write_word(w);
    @(posedge sclk_out);
    @(negedge clk); ext_fsync = 1'b1;
    @(posedge sclk_out);
    @(negedge clk); ext_fsync = 1'b0;
    @(negedge clk);
    chk("R9 mixed oe", {15'd0, txd_oe}, 16'd1);
    chk("R9 mixed msb", {15'd0, txd}, {15'd0, w[7]});
    for (int i = 1; i < 8; i++) begin
      @(posedge sclk_out); @(posedge clk); @(negedge clk);
      chk("R9 mixed bit", {15'd0, txd}, {15'd0, w[7-i]});
    end
    @(posedge sclk_out); @(posedge clk); @(negedge clk);
    chk("R9 mixed oe release", {15'd0, txd_oe}, 16'd0);
  endtask

  initial begin
    rst = 1'b1; cfg_wlen16 = 1'b0; cfg_int_clk = 1'b0; cfg_int_fs = 1'b0;
    ext_sclk = 1'b0; ext_fsync = 1'b0; wr_en = 1'b0; wr_data = '0;
    t_reset();
    t_frame(16'h7EA5, 1'b0, 1, 0, 1'b1, "R1 R2 R3 8-bit");
    t_frame(16'hC3E1, 1'b1, 1, 0, 1'b1, "R1 R2 16-bit");
    t_frame(16'h0096, 1'b0, 4, 0, 1'b1, "R5 long fsync");
    t_frame(16'h005C, 1'b0, 1, 4, 1'b1, "R4 busy fsync ignored");
    t_chain(16'h00B1, 16'h004E);
    t_underflow(16'h004E);
    t_internal(16'hA1C7);
    t_mixed(16'h00D2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule